// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the interlock and forwarding control of a five-stage in-order integer pipeline. It looks at the register numbers, write enables and load flags of the instructions in decode, execute, memory and write-back. From these it chooses where each ALU operand and the decode-stage branch comparator take their value from. It also decides when the front of the pipeline must hold, and when the instruction fetched behind a taken branch must be discarded. The block is purely combinational, so every output follows its inputs within the same cycle.

Branches test a single register against zero in decode and are predicted not taken. When a branch resolves taken, only the one instruction already fetched behind it is lost. Register 0 is hard-wired and never takes part in a dependency. The register file writes early in a cycle and reads late, so a write-back producer never needs a bypass into decode.

Top module: `hazard_bypass_ctrl`

## Requirements
- R1: Each ALU operand select is 2 bits: 0 = register file, 1 = ALU result held in EX/MEM, 2 = ALU result held in MEM/WB, 3 = load data held in MEM/WB. A non-load writer in the memory stage whose destination equals the operand's source gives select 1.
- R2: A writer in write-back whose destination equals the operand's source gives select 2 when it is not a load and select 3 when it is a load.
- R3: When the memory-stage and write-back writers both match one source, the memory-stage writer (the younger one) wins.
- R4: Register 0 never forwards, never stalls and never drives the branch bypass.
- R5: A valid decode instruction that uses a source matching the destination of a load in execute asserts pc_hold, ifid_hold and idex_bubble together.
- R6: No stall is raised for a non-branch consumer of an ALU result in execute, or for a source whose use flag is low.
- R7: A valid branch in decode stalls when its register is written by any instruction in execute or by a load in memory.
- R8: br_fwd (1 bit) is 1 when a non-load writer in memory matches the branch register, selecting the EX/MEM ALU result. A write-back writer leaves br_fwd at 0 and raises no stall.
- R9: A valid, unstalled branch whose outcome is taken asserts ifid_flush. A branch that is not taken does not.
- R10: When a branch stalls, ifid_flush stays low even if the taken input is high.
- R11: With id_valid low, neither stall nor flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src_a | input | 5 | First source register in decode |
| id_src_b | input | 5 | Second source register in decode |
| id_use_a | input | 1 | Decode instruction reads id_src_a |
| id_use_b | input | 1 | Decode instruction reads id_src_b |
| id_branch | input | 1 | Decode instruction is a zero-test branch on id_src_a |
| id_taken | input | 1 | Comparator outcome for the decode branch |
| ex_src_a | input | 5 | First source of the instruction in execute |
| ex_src_b | input | 5 | Second source of the instruction in execute |
| ex_dst | input | 5 | Destination of the instruction in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination of the instruction in memory |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Destination of the instruction in write-back |
| wb_wr | input | 1 | Write-back instruction writes a register |
| wb_load | input | 1 | Write-back instruction is a load |
| alu_a_sel | output | 2 | Source select of ALU operand A |
| alu_b_sel | output | 2 | Source select of ALU operand B |
| br_fwd | output | 1 | Branch comparator takes the EX/MEM ALU result |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the IF/ID register |
| idex_bubble | output | 1 | Load a no-op into ID/EX |
| ifid_flush | output | 1 | Clear the valid bit of IF/ID |

## Verification
The stall and the branch flush can both be demanded in the same cycle. This happens when a taken branch in decode reads a register that an instruction still in execute is producing. The bench provokes it by raising id_taken together with such a dependency and expects the hold and bubble outputs high with ifid_flush low. A matching vector then removes the dependency, and the flush must appear. The forwarding priority is judged the same way, with both downstream writers targeting one register in a single cycle.

// File: rtl/hazard_bypass_pkg.sv
package hazard_bypass_pkg;

    localparam int unsigned REG_AW = 5;

    typedef enum logic [1:0] {
        SRC_REGFILE    = 2'd0,
        SRC_EXMEM_ALU  = 2'd1,
        SRC_MEMWB_ALU  = 2'd2,
        SRC_MEMWB_LOAD = 2'd3
    } opnd_src_e;

    typedef struct packed {
        logic              wr;
        logic              load;
        logic [REG_AW-1:0] dst;
    } writer_t;

    // A writer matches a source only for a nonzero register number.
    function automatic logic writes_reg(writer_t w, logic [REG_AW-1:0] src);
        return w.wr && (w.dst == src) && (src != '0);
    endfunction

endpackage

// File: rtl/operand_pick.sv
module operand_pick
    import hazard_bypass_pkg::*;
(
    input  logic [REG_AW-1:0] src,
    input  writer_t           mem_w,
    input  writer_t           wb_w,
    output opnd_src_e         sel
);
    always_comb begin
        if (writes_reg(mem_w, src) && !mem_w.load) begin
            sel = SRC_EXMEM_ALU;
        end else if (writes_reg(wb_w, src)) begin
            sel = wb_w.load ? SRC_MEMWB_LOAD : SRC_MEMWB_ALU;
        end else begin
            sel = SRC_REGFILE;
        end
    end
endmodule

// File: rtl/stall_detect.sv
module stall_detect
    import hazard_bypass_pkg::*;
(
    input  logic              id_valid,
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic              use_a,
    input  logic              use_b,
    input  logic              branch,
    input  writer_t           ex_w,
    input  writer_t           mem_w,
    output logic              stall
);
    logic load_use;
    logic branch_wait;

    always_comb begin
        load_use = ex_w.load &&
                   ((use_a && writes_reg(ex_w, src_a)) ||
                    (use_b && writes_reg(ex_w, src_b)));
        branch_wait = branch &&
                      (writes_reg(ex_w, src_a) ||
                       (mem_w.load && writes_reg(mem_w, src_a)));
        stall = id_valid && (load_use || branch_wait);
    end
endmodule

// File: rtl/hazard_bypass_ctrl.sv
module hazard_bypass_ctrl
    import hazard_bypass_pkg::*;
#(
    parameter int unsigned NUM_OPND = 2
) (
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              id_use_a,
    input  logic              id_use_b,
    input  logic              id_branch,
    input  logic              id_taken,
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_wr,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr,
    input  logic              wb_load,
    output logic [1:0]        alu_a_sel,
    output logic [1:0]        alu_b_sel,
    output logic              br_fwd,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble,
    output logic              ifid_flush
);
    localparam int unsigned SEL_W = $bits(opnd_src_e);

    writer_t           ex_w, mem_w, wb_w;
    logic [REG_AW-1:0] ex_src [NUM_OPND];
    opnd_src_e         opnd_sel [NUM_OPND];
    logic              stall;

    assign ex_w  = '{wr: ex_wr,  load: ex_load,  dst: ex_dst};
    assign mem_w = '{wr: mem_wr, load: mem_load, dst: mem_dst};
    assign wb_w  = '{wr: wb_wr,  load: wb_load,  dst: wb_dst};

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        operand_pick u_pick (
            .src   (ex_src[g]),
            .mem_w (mem_w),
            .wb_w  (wb_w),
            .sel   (opnd_sel[g])
        );
    end

    assign alu_a_sel = SEL_W'(opnd_sel[0]);
    assign alu_b_sel = SEL_W'(opnd_sel[1]);

    stall_detect u_stall (
        .id_valid (id_valid),
        .src_a    (id_src_a),
        .src_b    (id_src_b),
        .use_a    (id_use_a),
        .use_b    (id_use_b),
        .branch   (id_branch),
        .ex_w     (ex_w),
        .mem_w    (mem_w),
        .stall    (stall)
    );

    // Comparator bypass: only an ALU result sitting in EX/MEM; write-back
    // producers reach decode through the register file in the same cycle.
    assign br_fwd      = id_branch && !mem_load && writes_reg(mem_w, id_src_a);
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
    assign ifid_flush  = id_valid && id_branch && id_taken && !stall;
endmodule

// File: rtl/hazard_bypass_chk.sv
module hazard_bypass_chk (
    input logic       id_valid,
    input logic [4:0] id_src_a,
    input logic       id_use_a,
    input logic [4:0] ex_src_a,
    input logic [4:0] ex_dst,
    input logic       ex_wr,
    input logic       ex_load,
    input logic       mem_wr,
    input logic       mem_load,
    input logic       wb_load,
    input logic [1:0] alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic       br_fwd,
    input logic       pc_hold,
    input logic       ifid_hold,
    input logic       idex_bubble,
    input logic       ifid_flush
);
    always_comb begin
        p_zero_no_fwd_r4: assert (ex_src_a != 5'd0 || alu_a_sel == 2'd0)
            else $error("register 0 forwarded");
        p_load_sel_r2: assert ((alu_a_sel != 2'd3 && alu_b_sel != 2'd3) || wb_load)
            else $error("load data selected without a load in write-back");
        p_load_use_r5: assert (!(id_valid && id_use_a && id_src_a != 5'd0 &&
                                 ex_wr && ex_load && ex_dst == id_src_a) ||
                               (pc_hold && ifid_hold && idex_bubble))
            else $error("load-use without stall");
        p_br_bypass_r8: assert (!br_fwd || (mem_wr && !mem_load))
            else $error("branch bypass without an ALU writer in memory");
        p_flush_vs_stall_r10: assert (!(ifid_flush && pc_hold))
            else $error("flush while stalled");
        p_no_valid_r11: assert (id_valid || (!pc_hold && !ifid_flush))
            else $error("action on invalid decode slot");
    end
endmodule

bind hazard_bypass_ctrl hazard_bypass_chk chk_i (
    .id_valid    (id_valid),
    .id_src_a    (id_src_a),
    .id_use_a    (id_use_a),
    .ex_src_a    (ex_src_a),
    .ex_dst      (ex_dst),
    .ex_wr       (ex_wr),
    .ex_load     (ex_load),
    .mem_wr      (mem_wr),
    .mem_load    (mem_load),
    .wb_load     (wb_load),
    .alu_a_sel   (alu_a_sel),
    .alu_b_sel   (alu_b_sel),
    .br_fwd      (br_fwd),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush)
);

// File: tb/hazard_bypass_ctrl_tb_top.sv
module hazard_bypass_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       id_valid, id_use_a, id_use_b, id_branch, id_taken;
    logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
    logic       ex_wr, ex_load, mem_wr, mem_load, wb_wr, wb_load;
    logic [1:0] alu_a_sel, alu_b_sel;
    logic       br_fwd, pc_hold, ifid_hold, idex_bubble, ifid_flush;

    hazard_bypass_ctrl dut_i (
        .id_valid(id_valid), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_use_a(id_use_a), .id_use_b(id_use_b), .id_branch(id_branch),
        .id_taken(id_taken), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
        .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_load(wb_load),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .br_fwd(br_fwd),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush)
    );

    typedef struct {
        logic [8:0] v;   // {a_sel, b_sel, br_fwd, pc_hold, ifid_hold, bubble, flush}
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic done   = 1'b0;

    task automatic clear_inputs();
        id_valid = 0; id_use_a = 0; id_use_b = 0; id_branch = 0; id_taken = 0;
        id_src_a = 0; id_src_b = 0; ex_src_a = 0; ex_src_b = 0; ex_dst = 0;
        ex_wr = 0; ex_load = 0; mem_dst = 0; mem_wr = 0; mem_load = 0;
        wb_dst = 0; wb_wr = 0; wb_load = 0;
    endtask

    // Driver: the inputs are already set; queue the expectation, advance.
    task automatic expect_out(string tag, logic [1:0] a, logic [1:0] b,
                              logic bf, logic stl, logic fl);
        exp_t e;
        e.v   = {a, b, bf, stl, stl, stl, fl};
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        clear_inputs();
    endtask

    // Monitor: compare away from the driving edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                logic [8:0] act;
                e   = q.pop_front();
                act = {alu_a_sel, alu_b_sel, br_fwd, pc_hold, ifid_hold,
                       idex_bubble, ifid_flush};
                checks++;
                if (act !== e.v) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(posedge clk);

        // Quiet state, decode slot empty
        expect_out("R11 idle", 2'd0, 2'd0, 0, 0, 0);

        ex_src_a = 3; mem_dst = 3; mem_wr = 1;
        expect_out("R1 EX/MEM alu", 2'd1, 2'd0, 0, 0, 0);

        ex_src_b = 4; wb_dst = 4; wb_wr = 1;
        expect_out("R2 MEM/WB alu", 2'd0, 2'd2, 0, 0, 0);

        ex_src_a = 6; wb_dst = 6; wb_wr = 1; wb_load = 1;
        expect_out("R2 MEM/WB load", 2'd3, 2'd0, 0, 0, 0);

        ex_src_a = 7; ex_src_b = 7; mem_dst = 7; mem_wr = 1; wb_dst = 7; wb_wr = 1;
        expect_out("R3 youngest wins", 2'd1, 2'd1, 0, 0, 0);

        mem_dst = 0; mem_wr = 1; wb_dst = 0; wb_wr = 1;
        id_valid = 1; id_use_a = 1; ex_dst = 0; ex_wr = 1; ex_load = 1;
        expect_out("R4 reg0 ignored", 2'd0, 2'd0, 0, 0, 0);

        id_valid = 1; id_use_b = 1; id_src_b = 9; ex_dst = 9; ex_wr = 1; ex_load = 1;
        expect_out("R5 load-use", 2'd0, 2'd0, 0, 1, 0);

        id_valid = 1; id_use_b = 1; id_src_b = 9; ex_dst = 9; ex_wr = 1;
        expect_out("R6 alu in EX no stall", 2'd0, 2'd0, 0, 0, 0);

        id_valid = 1; id_src_b = 9; ex_dst = 9; ex_wr = 1; ex_load = 1;
        expect_out("R6 unused source", 2'd0, 2'd0, 0, 0, 0);

        id_valid = 1; id_branch = 1; id_taken = 1; id_src_a = 10;
        ex_dst = 10; ex_wr = 1;
        expect_out("R7 R10 branch on EX alu", 2'd0, 2'd0, 0, 1, 0);

        id_valid = 1; id_branch = 1; id_src_a = 10;
        mem_dst = 10; mem_wr = 1; mem_load = 1;
        expect_out("R7 branch on MEM load", 2'd0, 2'd0, 0, 1, 0);

        id_valid = 1; id_branch = 1; id_taken = 1; id_src_a = 11;
        mem_dst = 11; mem_wr = 1;
        expect_out("R8 R9 bypass and flush", 2'd0, 2'd0, 1, 0, 1);

        id_valid = 1; id_branch = 1; id_src_a = 11;
        wb_dst = 11; wb_wr = 1; wb_load = 1;
        expect_out("R8 R9 WB no bypass not taken", 2'd0, 2'd0, 0, 0, 0);

        id_branch = 1; id_taken = 1; id_use_a = 1; id_src_a = 12;
        ex_dst = 12; ex_wr = 1; ex_load = 1;
        expect_out("R11 invalid slot", 2'd0, 2'd0, 0, 0, 0);

        id_valid = 1; id_branch = 1; id_src_a = 0; ex_dst = 0; ex_wr = 1;
        mem_dst = 0; mem_wr = 1;
        expect_out("R4 branch reg0", 2'd0, 2'd0, 0, 0, 0);

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule